// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block collects interrupt requests from banks of general-purpose input lines. The lines are organised in up to fifteen groups of sixteen (ten by default) and merged into one interrupt output for a host processor. Each input passes through a two-stage synchroniser. Next comes a trigger detector. Every run of four neighbouring lines shares one 4-bit trigger selector, which chooses low level, high level, falling edge, rising edge or both edges. A detected trigger sets a sticky pending bit. Software clears that bit by writing a one to it.

Software reaches the block over a simple synchronous register bus. Two neighbouring groups share each 32-bit trigger word, mask word and pending word. A read-only service word names the source that should be handled next, as a group field and a line field. Software reads the service word, handles that line, clears its pending bit and reads the service word again. It stops when the group field reads zero. The first group is wired to two banks of eight pins. Line numbers 0 to 7 of that group belong to the first bank and 8 to 15 to the second, so the service word identifies both banks.

Top module: `gpio_group_irq`

## Requirements
- R1: After reset every mask bit is 1, every pending bit and every trigger word is 0, `irq_o` is low and the service word reads 0.
- R2: `reg_addr[4:3]` selects the register class: 0 trigger words, 1 mask words, 2 pending words, 3 the service word. `reg_addr[2:0]` selects the word. Group g uses word g/2, and its line l sits at bit 16*(g%2)+l of that word.
- R3: The trigger of the line at word bit b comes from bits 4*(b/4)+3 down to 4*(b/4) of its trigger word. Code 0 means low level, 1 high level, 2 falling edge, 4 rising edge and 6 both edges. When bit 2 or bit 1 of the code is set, the code selects edge mode with those two bits as rising and falling enables. Bit 3 is ignored.
- R4: In a level mode a line sets its pending bit on every cycle that its synchronised input is at the active level. A clear made while the level persists is therefore undone.
- R5: In an edge mode a pending bit is set only by a transition of the selected direction on the synchronised input. A line held steady sets nothing.
- R6: A mask bit of 1 hides its line from `irq_o` and from the service word. The pending bit still latches events.
- R7: Writing a pending word clears exactly the bits written as 1. Bits written as 0 keep their value. A trigger event in the same cycle as a clear wins, and the bit stays set.
- R8: The service word carries the group number plus one in bits 7:4 and the line number within the group in bits 3:0. All other bits are 0. It reads 0 when no unmasked line is pending.
- R9: The service word names the lowest-numbered group that has a pending, unmasked line, and within that group the lowest line. It follows the current state on every cycle.
- R10: `irq_o` is high exactly when at least one line is both pending and unmasked.
- R11: Writes to the service word, and to any word index at or beyond (NUM_GROUPS+1)/2, change nothing. Reads of such word indexes return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | NUM_GROUPS*16 | Raw input lines; line l of group g is bit 16*g+l |
| reg_we | input | 1 | Write strobe for the register bus |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is the service choice when several groups hold pending lines under different masks at once. Some of those sources are level-triggered and refill as soon as they are cleared, while others are one-shot edges. The stimulus builds this up step by step. It latches edges on a low group while those lines are still masked, fills a higher group through a high-level selector, and then opens the masks one at a time. Between the steps it clears sources, so the service word has to move from the lowest line to the next group and then to a lower line inside that group.

// File: rtl/gpio_group_pkg.sv
package gpio_group_pkg;
   localparam int LINES_PER_GROUP = 16;
   localparam int WORD_W          = 32;
   localparam int SEL_W           = 4;
   localparam int LINES_PER_SEL   = 4;
   localparam int ADDR_W          = 5;

   typedef enum logic [1:0] {
      RG_TRIG = 2'd0,
      RG_MASK = 2'd1,
      RG_PEND = 2'd2,
      RG_SVC  = 2'd3
   } region_e;

   // Edge mode when either edge-enable bit is set, otherwise level mode.
   function automatic logic trig_event(input logic [SEL_W-1:0] sel,
                                       input logic cur, input logic prev);
      if (sel[2:1] != 2'b00)
         return (sel[2] & cur & ~prev) | (sel[1] & ~cur & prev);
      else
         return sel[0] ? cur : ~cur;
   endfunction
endpackage

// File: rtl/gpio_group_sync.sv
module gpio_group_sync #(
   parameter int WIDTH = 160
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] prev
);
   logic [WIDTH-1:0] meta;

   // Idle-high reset so that no transition appears while leaving reset.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         meta <= '1;
         cur  <= '1;
         prev <= '1;
      end else begin
         meta <= din;
         cur  <= meta;
         prev <= cur;
      end
   end
endmodule

// File: rtl/gpio_group_detect.sv
module gpio_group_detect
   import gpio_group_pkg::*;
#(
   parameter int NUM_WORDS = 5,
   localparam int NBITS    = NUM_WORDS * WORD_W
) (
   input  logic [NUM_WORDS-1:0][WORD_W-1:0] cfg,
   input  logic [NBITS-1:0]                 cur,
   input  logic [NBITS-1:0]                 prev,
   output logic [NBITS-1:0]                 evt
);
   for (genvar b = 0; b < NBITS; b++) begin : g_line
      localparam int W = b / WORD_W;
      localparam int O = b % WORD_W;
      localparam int S = SEL_W * (O / LINES_PER_SEL);
      assign evt[b] = trig_event(cfg[W][S +: SEL_W], cur[b], prev[b]);
   end
endmodule

// File: rtl/gpio_group_arbiter.sv
module gpio_group_arbiter
   import gpio_group_pkg::*;
#(
   parameter int NUM_GROUPS = 10,
   localparam int NBITS     = NUM_GROUPS * LINES_PER_GROUP
) (
   input  logic [NBITS-1:0] active,
   output logic [3:0]       svc_grp,
   output logic [3:0]       svc_line
);
   // Scan from the top down so that the lowest group and line are kept last.
   always_comb begin
      svc_grp  = 4'd0;
      svc_line = 4'd0;
      for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
         for (int l = LINES_PER_GROUP - 1; l >= 0; l--) begin
            if (active[g*LINES_PER_GROUP + l]) begin
               svc_grp  = 4'(g + 1);
               svc_line = 4'(l);
            end
         end
      end
   end
endmodule

// File: rtl/gpio_group_irq.sv
module gpio_group_irq
   import gpio_group_pkg::*;
#(
   parameter int NUM_GROUPS = 10
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_GROUPS*LINES_PER_GROUP-1:0] pins_i,
   input  logic                                reg_we,
   input  logic [ADDR_W-1:0]                   reg_addr,
   input  logic [WORD_W-1:0]                   reg_wdata,
   output logic [WORD_W-1:0]                   reg_rdata,
   output logic                                irq_o
);
   localparam int NW        = (NUM_GROUPS + 1) / 2;
   localparam int LINES_ALL = NW * WORD_W;
   localparam int USED      = NUM_GROUPS * LINES_PER_GROUP;
   localparam int PAD       = LINES_ALL - USED;
   localparam logic [LINES_ALL-1:0] USED_MASK = ((LINES_ALL)'(1) << USED) - 1'b1;

   if (NUM_GROUPS < 1 || NUM_GROUPS > 15) begin : g_bad_groups
      $error("NUM_GROUPS must lie in 1..15 so the group field can keep 0 for none");
   end

   logic [LINES_ALL-1:0]          pins_full, pin_cur, pin_prev, evt_raw, evt_used;
   logic [LINES_ALL-1:0]          mask_q, pend_q, clr, active;
   logic [NW-1:0][WORD_W-1:0]     cfg_q;
   logic [3:0]                    svc_grp, svc_line;
   region_e                       region;
   logic [2:0]                    widx;
   logic                          word_ok;

   if (PAD > 0) begin : g_pad
      assign pins_full = {{PAD{1'b1}}, pins_i};
   end else begin : g_nopad
      assign pins_full = pins_i;
   end

   gpio_group_sync #(.WIDTH(LINES_ALL)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pins_full),
      .cur  (pin_cur),
      .prev (pin_prev)
   );

   gpio_group_detect #(.NUM_WORDS(NW)) u_detect (
      .cfg (cfg_q),
      .cur (pin_cur),
      .prev(pin_prev),
      .evt (evt_raw)
   );

   assign evt_used = evt_raw & USED_MASK;
   assign active   = pend_q & ~mask_q;
   assign irq_o    = |active;

   gpio_group_arbiter #(.NUM_GROUPS(NUM_GROUPS)) u_arb (
      .active  (active[USED-1:0]),
      .svc_grp (svc_grp),
      .svc_line(svc_line)
   );

   // Address decode
   assign region  = region_e'(reg_addr[4:3]);
   assign widx    = reg_addr[2:0];
   assign word_ok = (int'(widx) < NW);

   always_comb begin
      clr = '0;
      if (reg_we && region == RG_PEND && word_ok)
         clr[WORD_W*int'(widx) +: WORD_W] = reg_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         mask_q <= '1;
         pend_q <= '0;
      end else begin
         if (reg_we && word_ok) begin
            case (region)
               RG_TRIG: cfg_q[widx] <= reg_wdata;
               RG_MASK: mask_q[WORD_W*int'(widx) +: WORD_W] <= reg_wdata;
               default: ;
            endcase
         end
         pend_q <= (pend_q & ~clr) | evt_used;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (region)
         RG_TRIG: if (word_ok) reg_rdata = cfg_q[widx];
         RG_MASK: if (word_ok) reg_rdata = mask_q[WORD_W*int'(widx) +: WORD_W];
         RG_PEND: if (word_ok) reg_rdata = pend_q[WORD_W*int'(widx) +: WORD_W];
         default: reg_rdata = {24'd0, svc_grp, svc_line};
      endcase
   end

   // Checks
   AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mask_q == '1 && pend_q == '0)); // R1

   AST_PEND_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(evt_used)) == '0)); // R5

   AST_SVC_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_grp != 4'd0) |-> active[{svc_grp - 4'd1, svc_line}]); // R6

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(clr) & ~$past(evt_used)) == '0)); // R7

   AST_GROUP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      svc_grp <= 4'(NUM_GROUPS)); // R8

   AST_IRQ_MATCHES_SVC: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (svc_grp != 4'd0)); // R10
endmodule

// File: tb/test_gpio_group_irq.sv
module test_gpio_group_irq;
   localparam int NG = 10;
   localparam int NP = NG * 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pins = '1;
   logic          reg_we = 1'b0;
   logic [4:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          irq_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   typedef struct {
      bit          is_irq;
      logic [4:0]  addr;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb[$];

   always #5 clk = ~clk;

   gpio_group_irq #(.NUM_GROUPS(NG)) i_gpio_group_irq (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_o(irq_o)
   );

   // Monitor: pops expected items and compares them away from the clock edge.
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            act = it.is_irq ? {31'd0, irq_o} : reg_rdata;
            total++;
            if (act !== it.exp) begin
               bad++;
               $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, act, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic expect_reg(input logic [4:0] a, input logic [31:0] e, input string t);
      @(negedge clk);
      reg_addr = a;
      sb.push_back('{1'b0, a, e, t});
   endtask

   task automatic expect_irq(input logic e, input string t);
      @(negedge clk);
      sb.push_back('{1'b1, 5'd0, {31'd0, e}, t});
   endtask

   task automatic set_pin(input int idx, input logic v);
      @(negedge clk);
      pins[idx] = v;
      repeat (4) @(posedge clk);
   endtask

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state, R2 layout of the classes
      for (int w = 0; w < 5; w++) begin
         expect_reg(5'(8 + w), 32'hFFFF_FFFF, "R1 mask");
         expect_reg(5'(16 + w), 32'h0, "R1 pending");
         expect_reg(5'(w), 32'h0, "R1 trigger");
      end
      expect_reg(5'd24, 32'h0, "R1 service");
      expect_irq(1'b0, "R1 irq");

      // R11 ignored writes and out-of-range words
      wr(5'd24, 32'hFF);
      expect_reg(5'd24, 32'h0, "R11 service write");
      wr(5'd6, 32'hFFFF_FFFF);
      expect_reg(5'd6, 32'h0, "R11 trigger word 6");
      wr(5'd13, 32'h0);
      expect_reg(5'd13, 32'h0, "R11 mask word 5");
      expect_irq(1'b0, "R11 irq");
      expect_reg(5'd0, 32'h0, "R11 trigger word 0 kept");

      // R3/R4: group 3 line 5 -> word 1 bit 21, selector bits 23:20 high level
      wr(5'd1, 32'h0010_0000);
      expect_reg(5'd17, 32'h00F0_0000, "R3 shared selector");
      expect_reg(5'd24, 32'h0, "R6 masked service");
      expect_irq(1'b0, "R6 masked irq");
      wr(5'd9, 32'hFFDF_FFFF);
      expect_reg(5'd24, 32'h45, "R8 group3 line5");
      expect_irq(1'b1, "R10 irq on");
      wr(5'd17, 32'h00F0_0000);
      expect_reg(5'd17, 32'h00F0_0000, "R4 level refills");
      wr(5'd1, 32'h0);
      wr(5'd17, 32'h00F0_0000);
      expect_reg(5'd17, 32'h0, "R7 cleared");
      expect_reg(5'd24, 32'h0, "R8 none");
      expect_irq(1'b0, "R10 irq off");

      // R5 rising-only on group 0 line 2
      wr(5'd0, 32'h4);
      wr(5'd8, 32'hFFFF_FFFB);
      set_pin(2, 1'b0);
      expect_reg(5'd16, 32'h0, "R5 falling ignored");
      set_pin(2, 1'b1);
      expect_reg(5'd16, 32'h4, "R5 rising");
      expect_reg(5'd24, 32'h12, "R8 group0 line2");
      expect_irq(1'b1, "R10 edge irq");
      wr(5'd16, 32'h200);
      expect_reg(5'd16, 32'h4, "R7 zero bits kept");
      wr(5'd16, 32'h4);
      expect_reg(5'd16, 32'h0, "R7 edge cleared");
      expect_irq(1'b0, "R10 after clear");

      // R5 falling on line 9, both edges on line 12
      wr(5'd0, 32'h6204);
      set_pin(9, 1'b0);
      set_pin(12, 1'b0);
      expect_reg(5'd16, 32'h1200, "R5 falling and both");
      expect_reg(5'd24, 32'h0, "R6 latched but masked");
      wr(5'd16, 32'h1000);
      expect_reg(5'd16, 32'h200, "R7 partial clear");
      set_pin(12, 1'b1);
      expect_reg(5'd16, 32'h1200, "R5 both edges rising");
      wr(5'd8, ~32'h1204);
      expect_reg(5'd24, 32'h19, "R9 lowest line");

      // R9 priority across groups: group 4 lines 0..3 high level
      wr(5'd2, 32'h1);
      expect_reg(5'd18, 32'h0000_000F, "R3 group4 selector");
      wr(5'd10, ~32'h8);
      expect_reg(5'd24, 32'h19, "R9 lower group wins");
      wr(5'd16, 32'h1200);
      expect_reg(5'd24, 32'h53, "R9 next group");
      wr(5'd10, ~32'hA);
      expect_reg(5'd24, 32'h51, "R9 lowest line in group");

      // Highest group, top line
      wr(5'd10, 32'hFFFF_FFFF);
      wr(5'd8, 32'hFFFF_FFFF);
      wr(5'd4, 32'h1000_0000);
      expect_reg(5'd20, 32'hF000_0000, "R2 group9 upper half");
      wr(5'd12, 32'h7FFF_FFFF);
      expect_reg(5'd24, 32'hAF, "R8 group9 line15");
      expect_irq(1'b1, "R10 top line");
      wr(5'd12, 32'hFFFF_FFFF);
      expect_reg(5'd24, 32'h0, "R6 all masked");
      expect_irq(1'b0, "R10 all masked");

      wait (sb.size() == 0);
      repeat (2) @(negedge clk);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule